// File: doc/BRIEF.md
# Legacy Expansion Bus 8-bit Memory Cycle Sequencer

This block is the host-side engine for 8-bit memory read and write cycles on a legacy PC-style expansion bus. An internal client presents an address, a direction and, for writes, a data byte. The sequencer then plays out one bus cycle. It pulses the address latch enable, drives the latchable upper address early so it can be pipelined, and holds the full lower address for the body of the cycle. It asserts the active-low read or write command and, on a read, returns the byte sampled from the data bus together with a one-clock completion pulse.

The block runs from a clock at twice the bus clock rate, so each bus state is two clock ticks. The first tick of a state is the high half of the bus clock and the second tick is the low half. The sequencer generates the bus clock itself on `bclk_o`. A cycle is made of a status state, a run of wait states and a command-execute state. The default number of wait states is a parameter, and it is four for the standard six-state cycle. A slow target can add wait states by pulling its ready line low. A fast target can skip the remaining default wait states by pulling the no-wait-state line low. If the ready line is held low too long, a watchdog ends the cycle and flags it.

Top module: `lbus_mem_seq`

## Requirements
- R1: With ready high and no-wait-state high, a cycle is one status state, DEF_WAITS wait states and one command state. That is DEF_WAITS+2 bus clocks, or six with the default of 4. `bclk_o` has a period of two `clk` ticks and is high in the first tick of each state.
- R2: `bale_o` is high only in the second half of the status state, for exactly one tick per cycle.
- R3: `la_en_o` is high from the first half of the status state through the first half of the state that follows it. While it is high, `la_o` carries address bits [ADDR_W-1:LA_LO].
- R4: `sa_en_o` is high from the second half of the status state through the end of the command state, plus one tick after. While it is high, `sa_o` carries address bits [SA_W-1:0].
- R5: During every wait state and the command state, `memr_n_o` is low for a read (`req_write_i`=0) and `memw_n_o` is low for a write (`req_write_i`=1). Both are high at all other times. On writes, `sd_oe_o` is high and `sd_o` carries the write byte over that same window.
- R6: `chrdy_i` is sampled low at the end of a wait state. The result is one added wait state, and it does not count toward the defaults. This takes priority over `nows_n_i`, so one such sample lengthens a default cycle to seven bus clocks.
- R7: `nows_n_i` is sampled low, with `chrdy_i` high, at the end of a wait state. The command state then follows directly. Asserted in the first wait state, this gives a three-bus-clock cycle.
- R8: After TO_LIMIT added wait states, `chrdy_i` may be sampled low once more. The cycle then moves to the command state, and `timeout_o` is 1 alongside `done_o`. Otherwise `timeout_o` is 0 with `done_o`. `timeout_o` holds until the next completion.
- R9: `done_o` is a one-tick pulse in the tick after the command state ends. On a read, `rdata_o` then holds `sd_i` as sampled on the last edge of the command state.
- R10: A request is taken only when the sequencer is idle and `bclk_o` is low. A request raised during a cycle is ignored, and the running cycle's address, direction and length are unchanged.
- R11: After reset, `bale_o`, `la_en_o`, `sa_en_o`, `sd_oe_o`, `done_o` and `timeout_o` are 0, and both command strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DW | Write byte |
| bclk_o | output | 1 | Generated bus clock |
| bale_o | output | 1 | Address latch enable |
| la_o | output | ADDR_W-LA_LO | Latchable upper address |
| la_en_o | output | 1 | Upper address drive enable |
| sa_o | output | SA_W | Lower address |
| sa_en_o | output | 1 | Lower address drive enable |
| memr_n_o | output | 1 | Memory read command, active low |
| memw_n_o | output | 1 | Memory write command, active low |
| sd_o | output | DW | Write data to the bus |
| sd_oe_o | output | 1 | Data bus drive enable |
| sd_i | input | DW | Data from the bus |
| chrdy_i | input | 1 | Target ready, low adds wait states |
| nows_n_i | input | 1 | No-wait-state request, active low |
| done_o | output | 1 | Cycle completion pulse |
| rdata_o | output | DW | Captured read byte |
| timeout_o | output | 1 | Last cycle ended by the ready watchdog |

## Verification
The bench builds the block with DEF_WAITS=4 and TO_LIMIT=3. Cycles keep the standard six-state shape, and the watchdog trips after only three added states. With these values, every mix of ready stall length and no-wait-state onset can be swept in both directions, including stalls that end just before, at and past the timeout. It covers no-wait-state requests that arrive while ready is still low, where priority matters, and requests raised mid-cycle that must be ignored.

// File: rtl/lbus_mem_seq_pkg.sv
package lbus_mem_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TS   = 2'd1,
      ST_TW   = 2'd2,
      ST_TC   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/lbus_mem_seq_ctrl.sv
module lbus_mem_seq_ctrl
   import lbus_mem_seq_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DW        = 8,
   parameter int DEF_WAITS = 4,
   parameter int TO_LIMIT  = 64,
   parameter bit NOWS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DW-1:0]     req_wdata_i,
   input  logic [DW-1:0]     sd_i,
   input  logic              chrdy_i,
   input  logic              nows_n_i,
   output seq_state_t        state_o,
   output logic              ph_o,
   output logic              first_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic [DW-1:0]     wdata_o,
   output logic              sa_hold_o,
   output logic              done_o,
   output logic [DW-1:0]     rdata_o,
   output logic              timeout_o
);
   localparam int WC_W = (DEF_WAITS < 2) ? 1 : $clog2(DEF_WAITS);
   localparam int EC_W = $clog2(TO_LIMIT + 1);
   localparam logic [WC_W-1:0] WC_LAST = WC_W'(DEF_WAITS - 1);
   localparam logic [EC_W-1:0] EC_LIM  = EC_W'(TO_LIMIT);

   if (DEF_WAITS < 1) begin : g_bad_waits
      $error("DEF_WAITS must be at least 1");
   end
   if (TO_LIMIT < 1) begin : g_bad_limit
      $error("TO_LIMIT must be at least 1");
   end

   seq_state_t        state_q;
   logic              ph_q;
   logic [WC_W-1:0]   wcnt_q;
   logic [EC_W-1:0]   ecnt_q;
   logic              to_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [DW-1:0]     wdata_q;
   logic              sa_hold_q;
   logic              done_q;
   logic [DW-1:0]     rdata_q;
   logic              timeout_q;
   logic              nows_act;

   if (NOWS_EN) begin : g_nows
      assign nows_act = ~nows_n_i;
   end else begin : g_no_nows
      assign nows_act = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q      <= 1'b0;
         state_q   <= ST_IDLE;
         wcnt_q    <= '0;
         ecnt_q    <= '0;
         to_q      <= 1'b0;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
         sa_hold_q <= 1'b0;
         done_q    <= 1'b0;
         rdata_q   <= '0;
         timeout_q <= 1'b0;
      end else begin
         ph_q      <= ~ph_q;
         done_q    <= 1'b0;
         sa_hold_q <= 1'b0;
         if (ph_q) begin
            case (state_q)
               ST_IDLE: begin
                  if (req_valid_i) begin
                     state_q <= ST_TS;
                     addr_q  <= req_addr_i;
                     wr_q    <= req_write_i;
                     wdata_q <= req_wdata_i;
                     wcnt_q  <= '0;
                     ecnt_q  <= '0;
                     to_q    <= 1'b0;
                  end
               end
               ST_TS: state_q <= ST_TW;
               ST_TW: begin
                  if (!chrdy_i) begin
                     if (ecnt_q == EC_LIM) begin
                        to_q    <= 1'b1;
                        state_q <= ST_TC;
                     end else begin
                        ecnt_q <= ecnt_q + 1'b1;
                     end
                  end else if (nows_act || wcnt_q == WC_LAST) begin
                     state_q <= ST_TC;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
               ST_TC: begin
                  state_q   <= ST_IDLE;
                  done_q    <= 1'b1;
                  sa_hold_q <= 1'b1;
                  timeout_q <= to_q;
                  if (!wr_q) rdata_q <= sd_i;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign state_o   = state_q;
   assign ph_o      = ph_q;
   assign first_o   = (wcnt_q == '0) && (ecnt_q == '0);
   assign addr_o    = addr_q;
   assign wr_o      = wr_q;
   assign wdata_o   = wdata_q;
   assign sa_hold_o = sa_hold_q;
   assign done_o    = done_q;
   assign rdata_o   = rdata_q;
   assign timeout_o = timeout_q;

   // R1: states change only at the end of the low half of the bus clock
   a_r1_state_on_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_q |=> $stable(state_q));
   // R6: a low ready sample below the limit keeps the cycle in wait
   a_r6_ready_extends: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TW && ph_q && !chrdy_i && ecnt_q != EC_LIM) |=> state_q == ST_TW);
   // R8: added wait count never passes the watchdog limit
   a_r8_ext_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt_q <= EC_LIM);
   // R9: completion is a single tick
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R10: a running cycle keeps its captured address
   a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: rtl/lbus_mem_seq_drv.sv
module lbus_mem_seq_drv
   import lbus_mem_seq_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LA_LO  = 17,
   parameter int SA_W   = 20,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state_i,
   input  logic              ph_i,
   input  logic              first_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              sa_hold_i,
   output logic              bclk_o,
   output logic              bale_o,
   output logic [ADDR_W-LA_LO-1:0] la_o,
   output logic              la_en_o,
   output logic [SA_W-1:0]   sa_o,
   output logic              sa_en_o,
   output logic              memr_n_o,
   output logic              memw_n_o,
   output logic [DW-1:0]     sd_o,
   output logic              sd_oe_o
);
   localparam int LA_W = ADDR_W - LA_LO;

   if (LA_W < 1 || SA_W > ADDR_W) begin : g_bad_addr
      $error("address split does not fit ADDR_W");
   end

   logic in_ts, in_tw, in_tc, cmd;

   always_comb begin
      in_ts    = (state_i == ST_TS);
      in_tw    = (state_i == ST_TW);
      in_tc    = (state_i == ST_TC);
      cmd      = in_tw | in_tc;
      bclk_o   = ~ph_i;
      bale_o   = in_ts & ph_i;
      la_en_o  = in_ts | (in_tw & first_i & ~ph_i);
      sa_en_o  = (in_ts & ph_i) | cmd | sa_hold_i;
      memr_n_o = ~(cmd & ~wr_i);
      memw_n_o = ~(cmd & wr_i);
      sd_oe_o  = cmd & wr_i;
      la_o     = la_en_o ? addr_i[ADDR_W-1:LA_LO] : '0;
      sa_o     = sa_en_o ? addr_i[SA_W-1:0] : '0;
      sd_o     = sd_oe_o ? wdata_i : '0;
   end

   // R2: address latch enable lasts one tick
   a_r2_bale_single: assert property (@(posedge clk) disable iff (!rst_n)
      bale_o |=> !bale_o);
   // R3: upper address is released while the command is already active
   a_r3_la_release_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(la_en_o) |-> (!memr_n_o || !memw_n_o));
   // R4: lower address covers every command tick
   a_r4_sa_covers_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (!memr_n_o || !memw_n_o) |-> sa_en_o);
   // R5: never both commands at once
   a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!memr_n_o && !memw_n_o));
endmodule

// File: rtl/lbus_mem_seq.sv
module lbus_mem_seq
   import lbus_mem_seq_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int LA_LO     = 17,
   parameter int SA_W      = 20,
   parameter int DW        = 8,
   parameter int DEF_WAITS = 4,
   parameter int TO_LIMIT  = 64,
   parameter bit NOWS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DW-1:0]     req_wdata_i,
   output logic              bclk_o,
   output logic              bale_o,
   output logic [ADDR_W-LA_LO-1:0] la_o,
   output logic              la_en_o,
   output logic [SA_W-1:0]   sa_o,
   output logic              sa_en_o,
   output logic              memr_n_o,
   output logic              memw_n_o,
   output logic [DW-1:0]     sd_o,
   output logic              sd_oe_o,
   input  logic [DW-1:0]     sd_i,
   input  logic              chrdy_i,
   input  logic              nows_n_i,
   output logic              done_o,
   output logic [DW-1:0]     rdata_o,
   output logic              timeout_o
);
   seq_state_t        state;
   logic              ph, first, wr, sa_hold;
   logic [ADDR_W-1:0] addr;
   logic [DW-1:0]     wdata;

   lbus_mem_seq_ctrl #(
      .ADDR_W(ADDR_W), .DW(DW), .DEF_WAITS(DEF_WAITS),
      .TO_LIMIT(TO_LIMIT), .NOWS_EN(NOWS_EN)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .sd_i(sd_i), .chrdy_i(chrdy_i), .nows_n_i(nows_n_i),
      .state_o(state), .ph_o(ph), .first_o(first), .addr_o(addr),
      .wr_o(wr), .wdata_o(wdata), .sa_hold_o(sa_hold),
      .done_o(done_o), .rdata_o(rdata_o), .timeout_o(timeout_o)
   );

   lbus_mem_seq_drv #(
      .ADDR_W(ADDR_W), .LA_LO(LA_LO), .SA_W(SA_W), .DW(DW)
   ) drv_i (
      .clk(clk), .rst_n(rst_n),
      .state_i(state), .ph_i(ph), .first_i(first), .addr_i(addr),
      .wr_i(wr), .wdata_i(wdata), .sa_hold_i(sa_hold),
      .bclk_o(bclk_o), .bale_o(bale_o), .la_o(la_o), .la_en_o(la_en_o),
      .sa_o(sa_o), .sa_en_o(sa_en_o), .memr_n_o(memr_n_o),
      .memw_n_o(memw_n_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
   );
endmodule

// File: tb/lbus_mem_seq_tb_top.sv
`timescale 1ns/1ps
module lbus_mem_seq_tb_top;
   localparam int ADDR_W = 24;
   localparam int LA_LO  = 17;
   localparam int SA_W   = 20;
   localparam int DW     = 8;
   localparam int DEFW   = 4;
   localparam int LIM    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0, sd_in = '0;
   logic chrdy = 1'b1, nows_n = 1'b1;
   logic bclk, bale, la_en, sa_en, memr_n, memw_n, sd_oe, done, timeout;
   logic [ADDR_W-LA_LO-1:0] la;
   logic [SA_W-1:0] sa;
   logic [DW-1:0] sd_out, rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lbus_mem_seq #(
      .ADDR_W(ADDR_W), .LA_LO(LA_LO), .SA_W(SA_W), .DW(DW),
      .DEF_WAITS(DEFW), .TO_LIMIT(LIM), .NOWS_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .bclk_o(bclk), .bale_o(bale), .la_o(la), .la_en_o(la_en),
      .sa_o(sa), .sa_en_o(sa_en), .memr_n_o(memr_n), .memw_n_o(memw_n),
      .sd_o(sd_out), .sd_oe_o(sd_oe), .sd_i(sd_in),
      .chrdy_i(chrdy), .nows_n_i(nows_n),
      .done_o(done), .rdata_o(rdata), .timeout_o(timeout)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One bus cycle with a ready stall over waits 1..stall and a
   // no-wait-state request from wait nows_from on (0 = never).
   task automatic run_cycle(input bit wr, input logic [ADDR_W-1:0] addr,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                            input int stall, input int nows_from);
      int w, dn, last, s;
      bit to_exp;
      string lreq;
      bit e_bale, e_la, e_sa, e_cmd, e_done;
      if (stall >= LIM + 1) begin
         w = LIM + 1; to_exp = 1'b1; lreq = "R8";
      end else begin
         dn = (nows_from == 0) ? DEFW : ((nows_from - stall) < 1 ? 1 : nows_from - stall);
         if (dn > DEFW) dn = DEFW;
         w = stall + dn; to_exp = 1'b0;
         lreq = (stall > 0) ? "R6" : ((nows_from != 0 && dn < DEFW) ? "R7" : "R1");
      end
      last = 2 * w + 5;
      @(negedge clk);
      while (bclk) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      sd_in = ~rd;
      for (int n = 1; n <= last + 1; n++) begin
         @(negedge clk);
         s = (n - 1) / 2;
         if (n == 1) req_valid = 1'b0;
         if (n == 6) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~addr;
         end
         if (n == 7) req_valid = 1'b0;
         chrdy  = !(s >= 1 && s <= w && s <= stall);
         nows_n = !(s >= 1 && s <= w && nows_from != 0 && s >= nows_from);
         sd_in  = (s == w + 1) ? rd : ~rd;
         e_bale = (n == 2);
         e_la   = (n >= 1 && n <= 3);
         e_sa   = (n >= 2 && n <= last);
         e_cmd  = (n >= 3 && n <= last - 1);
         e_done = (n == last);
         chk(bclk == n[0], "R1", "bus clock phase", bclk, n[0]);
         chk(bale == e_bale, "R2", "bale", bale, e_bale);
         chk(la_en == e_la, "R3", "la enable", la_en, e_la);
         if (e_la) chk(la == addr[ADDR_W-1:LA_LO], "R3", "la value", la, addr[ADDR_W-1:LA_LO]);
         chk(sa_en == e_sa, "R4", "sa enable", sa_en, e_sa);
         if (e_sa) chk(sa == addr[SA_W-1:0], (n > 6) ? "R10" : "R4", "sa value", sa, addr[SA_W-1:0]);
         chk(memr_n == !(e_cmd && !wr), "R5", "read command", memr_n, !(e_cmd && !wr));
         chk(memw_n == !(e_cmd && wr), "R5", "write command", memw_n, !(e_cmd && wr));
         chk(sd_oe == (e_cmd && wr), "R5", "data enable", sd_oe, e_cmd && wr);
         if (e_cmd && wr) chk(sd_out == wd, "R5", "write data", sd_out, wd);
         chk(done == e_done, lreq, "done timing", done, e_done);
         if (e_done) begin
            chk(timeout == to_exp, "R8", "timeout flag", timeout, to_exp);
            if (!wr) chk(rdata == rd, "R9", "read data", rdata, rd);
         end
      end
      chrdy = 1'b1; nows_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int idx;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bale && !la_en && !sa_en && !sd_oe, "R11", "idle enables",
          {bale, la_en, sa_en, sd_oe}, 0);
      chk(memr_n && memw_n, "R11", "idle commands", {memr_n, memw_n}, 3);
      chk(!done && !timeout, "R11", "idle done/timeout", {done, timeout}, 0);
      idx = 0;
      for (int wr = 0; wr < 2; wr++) begin
         for (int st = 0; st <= LIM + 2; st++) begin
            for (int nk = 0; nk < 5; nk++) begin
               int nf;
               logic [ADDR_W-1:0] a;
               nf = (nk == 4) ? 5 : nk;
               a = (ADDR_W'(1) << (idx % ADDR_W)) ^ ADDR_W'(idx * 32'h3A5C7);
               run_cycle(wr[0], a, DW'(idx * 37 + 5), DW'(idx * 53 + 11), st, nf);
               idx++;
            end
         end
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule